// File: doc/BRIEF.md
# Programmable 64-Line Interrupt Controller

The block gathers 64 interrupt request lines and reduces them to one interrupt output for a processor. Every request line has its own configuration byte on a small synchronous register bus. The byte turns the line on or off and picks how the line is interpreted: as an active-high level, as a rising-edge event or as a falling-edge event. Edge events are caught in two 32-bit status words. Software clears a caught event by writing a one to its bit. A level line is silenced by turning it off in its configuration byte.

Among the lines that are both turned on and asking, an arbiter picks one winner and publishes its number in a grant word. Software reads the grant word to find out which line to service. By default the lowest number always wins. With the rotate bit set in the priority word, the search instead begins just above the line most recently handed out through a grant read, so that a busy low-numbered line cannot starve the others.

Top module: `irq_hub64`

## Requirements
- R1: After reset every configuration byte, both status words, the priority word (0x20) and the auxiliary word (0x24) read as zero, `irq_o` is low and the grant word reads zero.
- R2: Line n owns the configuration byte at address 0x40 + n, which sits in byte lane n mod 4 of the word at 0x40 + 4*(n/4). Bit 3 is the enable and bits 5:4 are the trigger mode. Only byte lanes whose `bus_be` bit is set are written. Bits 7:6 and 2:0 read as zero.
- R3: In mode 0 (and the unused mode 3) a line acts as an active-high level. It asks for service while it is enabled and its input is high. Its status bit always reads 0, and a one written to that bit has no effect.
- R4: In mode 1 a low-to-high change of the input, as seen between two consecutive clock samples, sets status bit n mod 32. Lines 0–31 use the word at 0x80 and lines 32–63 use the word at 0x84. The bit stays set after the input falls.
- R5: In mode 2 a high-to-low change sets the status bit, and a low-to-high change does not.
- R6: An edge is latched even while its line is disabled. A disabled line never drives `irq_o`. Enabling a line whose status bit is already set makes it ask for service.
- R7: Writing a status word clears exactly the bits that are written as one, within the enabled byte lanes. Bits written as zero keep their value.
- R8: `irq_o` is registered. It rises one clock after an enabled level input is first sampled high. It rises two clocks after a line's edge is sampled: one clock to latch the status bit and one more to assert the output.
- R9: The grant word at 0x00 holds the winning line number in bits 5:0 and a valid flag in bit 8. The valid flag is set whenever any enabled line is asking for service. Reading the grant word while it is valid records that line number as the most recently granted line.
- R10: With bit 6 of the priority word clear, the lowest-numbered line that is asking wins.
- R11: With bit 6 of the priority word set, the search starts one above the most recently granted line and wraps from 63 back to 0. Before any grant has been read, the search starts at 0.
- R12: Read data appears on `bus_rdata` one clock after the read is presented. The words at 0x20 and 0x24 read back what was written. Unmapped addresses read as zero. An access whose address bits 1:0 are not zero does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 64 | Interrupt request lines, one per line number |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_be | input | 4 | Byte lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the clock after a read |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench sweeps every line through level mode, rising mode and falling mode. For each line it checks the status word and bit position, the grant number and the clear. A design that mixes up the two status words or the bit offset fails on the first line above 31. A design that catches the wrong edge in falling mode shows a status bit while the input is still high.

The bench latches an edge on a disabled line and then enables that line. A design that gates the latch with the enable loses that event. Writing ones to a level line's status bit must leave the output asserted, and a clear written with zero bits must leave the other caught events in place.

The priority run programs three lines and reads the grant repeatedly. In fixed mode the lowest line must win on every read. In rotating mode the winner must step through the three lines and wrap from the top line back to the bottom one. An arbiter that rotates on every cycle, or that never advances its pointer, returns a different sequence.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

    localparam int unsigned BUS_AW = 8;
    localparam int unsigned BUS_DW = 32;

    typedef enum logic [1:0] {
        TRIG_LVL_HI = 2'd0,
        TRIG_RISE   = 2'd1,
        TRIG_FALL   = 2'd2,
        TRIG_RSVD   = 2'd3
    } trig_mode_e;

    localparam logic [BUS_AW-1:0] ADDR_GRANT   = 8'h00;
    localparam logic [BUS_AW-1:0] ADDR_PRIO    = 8'h20;
    localparam logic [BUS_AW-1:0] ADDR_AUX     = 8'h24;
    localparam logic [BUS_AW-1:0] ADDR_STAT_LO = 8'h80;
    localparam logic [BUS_AW-1:0] ADDR_STAT_HI = 8'h84;
    localparam logic [1:0]        CFG_PAGE     = 2'b01;

    localparam int CFG_EN_BIT   = 3;
    localparam int CFG_MODE_LSB = 4;
    localparam int PRIO_ROT_BIT = 6;
    localparam int GRANT_VLD    = 8;

    typedef struct packed {
        logic [BUS_DW-1:0] prio;
        logic [BUS_DW-1:0] aux;
        logic [BUS_DW-1:0] rdata;
    } hub_regs_t;

    function automatic logic mode_is_edge(trig_mode_e m);
        return (m == TRIG_RISE) || (m == TRIG_FALL);
    endfunction

    function automatic logic [BUS_DW-1:0] lane_mask(logic [BUS_DW/8-1:0] be);
        logic [BUS_DW-1:0] m;
        for (int i = 0; i < BUS_DW/8; i++) begin
            m[8*i +: 8] = {8{be[i]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot
    import irq_hub_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       src_i,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    input  logic       stat_clr,
    output logic       en_o,
    output trig_mode_e mode_o,
    output logic       stat_o,
    output logic       pend_o
);

    typedef struct packed {
        logic       en;
        trig_mode_e mode;
        logic       prev;
        logic       stat;
    } slot_t;

    slot_t q, d;
    logic  evt;

    always_comb begin
        d = q;
        unique case (q.mode)
            TRIG_RISE: evt = src_i & ~q.prev;
            TRIG_FALL: evt = ~src_i & q.prev;
            default:   evt = 1'b0;
        endcase
        d.prev = src_i;
        if (mode_is_edge(q.mode)) begin
            d.stat = (q.stat & ~stat_clr) | evt;
        end else begin
            d.stat = 1'b0;
        end
        if (cfg_we) begin
            d.en   = cfg_wdata[CFG_EN_BIT];
            d.mode = trig_mode_e'(cfg_wdata[CFG_MODE_LSB +: 2]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{en: 1'b0, mode: TRIG_LVL_HI, prev: 1'b0, stat: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign en_o   = q.en;
    assign mode_o = q.mode;
    assign stat_o = q.stat;
    assign pend_o = q.en & (mode_is_edge(q.mode) ? q.stat : src_i);

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int SRC_N = 64,
    localparam int IDX_W = $clog2(SRC_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] pend_i,
    input  logic             rotate_i,
    input  logic             claim_i,
    output logic [IDX_W-1:0] win_idx_o,
    output logic             win_vld_o
);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             vld;
        logic [IDX_W-1:0] last;
    } arb_t;

    arb_t q, d;

    logic [IDX_W-1:0]   start;
    logic [2*SRC_N-1:0] dbl;
    logic [SRC_N-1:0]   rot;
    logic [IDX_W-1:0]   pos;

    always_comb begin
        d     = q;
        start = rotate_i ? q.last + IDX_W'(1) : '0;
        dbl   = {pend_i, pend_i} >> start;
        rot   = dbl[SRC_N-1:0];
        pos   = '0;
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if (rot[i]) pos = IDX_W'(i);
        end
        d.vld = |pend_i;
        d.idx = d.vld ? start + pos : '0;
        if (claim_i && q.vld) begin
            d.last = q.idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{idx: '0, vld: 1'b0, last: '1};
        end else begin
            q <= d;
        end
    end

    assign win_idx_o = q.idx;
    assign win_vld_o = q.vld;

endmodule

// File: rtl/irq_hub64.sv
module irq_hub64
    import irq_hub_pkg::*;
#(
    parameter int SRC_N = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  src_i,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              irq_o
);

    localparam int IDX_W = $clog2(SRC_N);
    localparam int LANES = BUS_DW / 8;

    hub_regs_t q, d;

    logic             acc_ok, wr_stb, rd_stb, claim, rotate_en;
    logic [BUS_DW-1:0] wmask, rd_word;
    logic [SRC_N-1:0] cfg_we, clr, pend_vec, stat_vec, en_vec, lvl_vec;
    logic [7:0]       cfg_byte [SRC_N];
    trig_mode_e       mode_vec [SRC_N];
    logic [IDX_W-1:0] win_idx;
    logic             win_vld;

    assign acc_ok    = bus_sel && (bus_addr[1:0] == 2'b00);
    assign wr_stb    = acc_ok && bus_wr;
    assign rd_stb    = acc_ok && !bus_wr;
    assign wmask     = lane_mask(bus_be);
    assign claim     = rd_stb && (bus_addr == ADDR_GRANT);
    assign rotate_en = q.prio[PRIO_ROT_BIT];

    for (genvar n = 0; n < SRC_N; n++) begin : g_slot
        localparam int LANE = n % LANES;
        localparam int WORD = n / LANES;
        localparam logic [BUS_AW-1:0] STAT_ADDR = (n < 32) ? ADDR_STAT_LO : ADDR_STAT_HI;

        assign cfg_we[n] = wr_stb && (bus_addr[7:6] == CFG_PAGE) &&
                           (bus_addr[5:2] == 4'(WORD)) && bus_be[LANE];
        assign clr[n]    = wr_stb && (bus_addr == STAT_ADDR) &&
                           bus_be[(n % 32) / 8] && bus_wdata[n % 32];

        irq_src_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_i     (src_i[n]),
            .cfg_we    (cfg_we[n]),
            .cfg_wdata (bus_wdata[8*LANE +: 8]),
            .stat_clr  (clr[n]),
            .en_o      (en_vec[n]),
            .mode_o    (mode_vec[n]),
            .stat_o    (stat_vec[n]),
            .pend_o    (pend_vec[n])
        );

        assign lvl_vec[n]  = !mode_is_edge(mode_vec[n]);
        assign cfg_byte[n] = {2'b00, mode_vec[n], en_vec[n], 3'b000};
    end

    irq_arbiter #(.SRC_N(SRC_N)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_i    (pend_vec),
        .rotate_i  (rotate_en),
        .claim_i   (claim),
        .win_idx_o (win_idx),
        .win_vld_o (win_vld)
    );

    always_comb begin
        rd_word = '0;
        if (bus_addr[7:6] == CFG_PAGE) begin
            for (int b = 0; b < LANES; b++) begin
                rd_word[8*b +: 8] = cfg_byte[{bus_addr[5:2], 2'(b)}];
            end
        end else begin
            unique case (bus_addr)
                ADDR_GRANT: begin
                    rd_word[IDX_W-1:0] = win_idx;
                    rd_word[GRANT_VLD] = win_vld;
                end
                ADDR_PRIO:    rd_word = q.prio;
                ADDR_AUX:     rd_word = q.aux;
                ADDR_STAT_LO: rd_word = stat_vec[31:0];
                ADDR_STAT_HI: rd_word = stat_vec[SRC_N-1:32];
                default:      rd_word = '0;
            endcase
        end
    end

    always_comb begin
        d = q;
        if (wr_stb && bus_addr == ADDR_PRIO) begin
            d.prio = (q.prio & ~wmask) | (bus_wdata & wmask);
        end
        if (wr_stb && bus_addr == ADDR_AUX) begin
            d.aux = (q.aux & ~wmask) | (bus_wdata & wmask);
        end
        if (rd_stb) begin
            d.rdata = rd_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign bus_rdata = q.rdata;
    assign irq_o     = win_vld;

endmodule

// File: rtl/irq_hub64_checker.sv
module irq_hub64_checker #(
    parameter int SRC_N = 64,
    localparam int IDX_W = $clog2(SRC_N)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_o,
    input logic [SRC_N-1:0] pend_vec,
    input logic [SRC_N-1:0] stat_vec,
    input logic [SRC_N-1:0] en_vec,
    input logic [SRC_N-1:0] lvl_vec,
    input logic [IDX_W-1:0] win_idx,
    input logic             rotate_en
);

    assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == $past(|pend_vec));

    assert_winner_asking_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((($past(pend_vec) >> win_idx) & {{(SRC_N-1){1'b0}}, 1'b1}) != '0));

    assert_fixed_lowest_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !$past(rotate_en)) |->
        (($past(pend_vec) & ((({{(SRC_N-1){1'b0}}, 1'b1}) << win_idx) - 1'b1)) == '0));

    assert_level_no_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_vec & $past(lvl_vec)) == '0);

    assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en_vec) == '0) |-> !irq_o);

endmodule

bind irq_hub64 irq_hub64_checker #(.SRC_N(SRC_N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_o     (irq_o),
    .pend_vec  (pend_vec),
    .stat_vec  (stat_vec),
    .en_vec    (en_vec),
    .lvl_vec   (lvl_vec),
    .win_idx   (win_idx),
    .rotate_en (rotate_en)
);

// File: tb/irq_hub64_bench.sv
module irq_hub64_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src = '0;
    logic        sel = 1'b0, wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [3:0]  be = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    irq_hub64 u_irq_hub64 (
        .clk(clk), .rst_n(rst_n), .src_i(src),
        .bus_sel(sel), .bus_wr(wr), .bus_addr(addr), .bus_be(be),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [3:0] b, input logic [31:0] v);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; be = b; wdata = v;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; be = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        @(negedge clk);
        sel = 1'b0;
        v = rdata;
        @(negedge clk);
    endtask

    task automatic expect_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        bus_read(a, v);
        check(v == exp, tag, 64'(v), 64'(exp));
    endtask

    function automatic logic [7:0] cfg_addr(input int n);
        return 8'h40 + 8'((n / 4) * 4);
    endfunction

    task automatic set_cfg(input int n, input logic [7:0] val);
        bus_write(cfg_addr(n), 4'(1 << (n % 4)), 32'(val) << (8 * (n % 4)));
    endtask

    task automatic fill_cfg(input logic [7:0] val);
        for (int k = 0; k < 16; k++) bus_write(8'h40 + 8'(4 * k), 4'hF, {4{val}});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        cyc(3);
        rst_n = 1'b1;
        cyc(2);

        // R1 reset state
        check(irq == 1'b0, "R1 irq after reset", 64'(irq), 0);
        expect_rd(8'h00, 32'h0, "R1 grant");
        expect_rd(8'h80, 32'h0, "R1 status lo");
        expect_rd(8'h84, 32'h0, "R1 status hi");
        expect_rd(8'h20, 32'h0, "R1 prio");
        expect_rd(8'h24, 32'h0, "R1 aux");
        expect_rd(8'h40, 32'h0, "R1 cfg first");
        expect_rd(8'h7C, 32'h0, "R1 cfg last");

        // R12 register storage and unmapped space
        bus_write(8'h24, 4'hF, 32'hA5C3_5A3C);
        expect_rd(8'h24, 32'hA5C3_5A3C, "R12 aux readback");
        bus_write(8'h24, 4'b0100, 32'h0011_0000);
        expect_rd(8'h24, 32'hA511_5A3C, "R12 aux byte lane");
        expect_rd(8'h10, 32'h0, "R12 unmapped");
        bus_write(8'h21, 4'hF, 32'hFFFF_FFFF);
        expect_rd(8'h20, 32'h0, "R12 misaligned write ignored");

        // R2 byte lanes and field masking
        bus_write(8'h40, 4'b0010, 32'hFFFF_FFFF);
        expect_rd(8'h40, 32'h0000_3800, "R2 lane 1 only, masked bits");
        bus_write(8'h40, 4'hF, 32'h0);

        // R3/R9 level sweep over every line
        for (int n = 0; n < 64; n++) begin
            set_cfg(n, 8'h08);
            src[n] = 1'b1;
            cyc(2);
            check(irq == 1'b1, $sformatf("R3 level line %0d irq", n), 64'(irq), 1);
            expect_rd(8'h00, 32'h100 | 32'(n), $sformatf("R9 grant level line %0d", n));
            src[n] = 1'b0;
            cyc(2);
            check(irq == 1'b0, $sformatf("R3 level line %0d released", n), 64'(irq), 0);
            set_cfg(n, 8'h00);
        end

        // R3 disabled level line stays quiet
        src[10] = 1'b1;
        cyc(3);
        check(irq == 1'b0, "R3 disabled level line", 64'(irq), 0);
        src[10] = 1'b0;

        // R4/R5/R7 edge sweep, rising then falling
        for (int m = 1; m <= 2; m++) begin
            fill_cfg(8'(8'h08 | (m << 4)));
            cyc(2);
            for (int n = 0; n < 64; n++) begin
                logic [7:0]  sa;
                logic [31:0] bit_n;
                sa    = (n < 32) ? 8'h80 : 8'h84;
                bit_n = 32'd1 << (n % 32);
                src[n] = 1'b1;
                if (m == 1) begin
                    cyc(1);
                    src[n] = 1'b0;
                    cyc(3);
                end else begin
                    cyc(3);
                    expect_rd(sa, 32'h0, $sformatf("R5 rise ignored line %0d", n));
                    src[n] = 1'b0;
                    cyc(3);
                end
                expect_rd(8'h80, (n < 32) ? bit_n : 32'h0, $sformatf("R4 mode %0d line %0d status lo", m, n));
                expect_rd(8'h84, (n < 32) ? 32'h0 : bit_n, $sformatf("R4 mode %0d line %0d status hi", m, n));
                check(irq == 1'b1, $sformatf("R4 mode %0d line %0d irq", m, n), 64'(irq), 1);
                expect_rd(8'h00, 32'h100 | 32'(n), $sformatf("R9 grant edge line %0d", n));
                bus_write(sa, 4'hF, bit_n);
                cyc(2);
                check(irq == 1'b0, $sformatf("R7 clear line %0d", n), 64'(irq), 0);
                expect_rd(sa, 32'h0, $sformatf("R7 status cleared line %0d", n));
            end
        end

        // R7 zero bits keep their value
        fill_cfg(8'h18);
        src[3] = 1'b1; src[4] = 1'b1;
        cyc(1);
        src[3] = 1'b0; src[4] = 1'b0;
        cyc(2);
        bus_write(8'h80, 4'hF, 32'h0000_0008);
        cyc(1);
        expect_rd(8'h80, 32'h0000_0010, "R7 only written one cleared");
        bus_write(8'h80, 4'hF, 32'h0000_0010);
        fill_cfg(8'h00);

        // R6 latch while disabled, then enable
        set_cfg(33, 8'h10);
        src[33] = 1'b1;
        cyc(1);
        src[33] = 1'b0;
        cyc(3);
        expect_rd(8'h84, 32'h0000_0002, "R6 latched while disabled");
        check(irq == 1'b0, "R6 disabled line quiet", 64'(irq), 0);
        set_cfg(33, 8'h18);
        cyc(2);
        check(irq == 1'b1, "R6 enabled after latch", 64'(irq), 1);
        bus_write(8'h84, 4'hF, 32'h0000_0002);
        set_cfg(33, 8'h00);

        // R3 write-one to a level line status has no effect
        set_cfg(2, 8'h08);
        src[2] = 1'b1;
        cyc(2);
        expect_rd(8'h80, 32'h0, "R3 level status reads zero");
        bus_write(8'h80, 4'hF, 32'h0000_0004);
        cyc(2);
        check(irq == 1'b1, "R3 level unaffected by clear", 64'(irq), 1);
        src[2] = 1'b0;
        set_cfg(2, 8'h00);
        cyc(2);

        // R8 latency
        set_cfg(12, 8'h08);
        cyc(1);
        src[12] = 1'b1;
        check(irq == 1'b0, "R8 level before edge", 64'(irq), 0);
        cyc(1);
        check(irq == 1'b1, "R8 level one clock", 64'(irq), 1);
        src[12] = 1'b0;
        set_cfg(12, 8'h00);
        set_cfg(13, 8'h18);
        cyc(2);
        src[13] = 1'b1;
        cyc(1);
        check(irq == 1'b0, "R8 edge after one clock", 64'(irq), 0);
        cyc(1);
        check(irq == 1'b1, "R8 edge after two clocks", 64'(irq), 1);
        src[13] = 1'b0;
        bus_write(8'h80, 4'hF, 32'h0000_2000);
        set_cfg(13, 8'h00);
        cyc(2);

        // R10 fixed priority, then R11 rotating
        set_cfg(5, 8'h08); set_cfg(20, 8'h08); set_cfg(40, 8'h08);
        src[5] = 1'b1; src[20] = 1'b1; src[40] = 1'b1;
        cyc(2);
        expect_rd(8'h00, 32'h105, "R10 fixed first read");
        expect_rd(8'h00, 32'h105, "R10 fixed second read");
        bus_write(8'h20, 4'hF, 32'h0000_0040);
        expect_rd(8'h20, 32'h0000_0040, "R12 prio readback");
        cyc(1);
        expect_rd(8'h00, 32'h100 | 32'd20, "R11 rotate after 5");
        expect_rd(8'h00, 32'h100 | 32'd40, "R11 rotate after 20");
        expect_rd(8'h00, 32'h100 | 32'd5,  "R11 rotate wraps to 5");
        expect_rd(8'h00, 32'h100 | 32'd20, "R11 rotate back to 20");
        src = '0;
        cyc(2);
        expect_rd(8'h00, 32'h0, "R9 grant invalid when idle");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule